// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a single-port synchronous SRAM with a flow-through read path. A transfer begins when one of two active-low address strobes is sampled low: the processor strobe or the controller strobe. After that, the block generates up to four word addresses from a 2-bit beat counter. The block has three chip selects, global and per-lane writes, and an output-drive flag that a pad ring would use to steer a shared data bus. Each lane holds one data byte and one parity bit.

Each clock edge either starts a transfer, continues the current burst, or leaves the block deselected. A start loads the full address. The two low address bits become the burst base offset, and the beat count is cleared. While a burst is active, each edge with the advance input low steps the beat. The word offset is either the base plus the beat, wrapping modulo 4, or the base XOR the beat, chosen by a static order input. A write on an edge stores data at the address in effect after that edge. Read data for the address in effect is presented combinationally during the following cycle.

Top module: `burst_sram`

## Requirements
- R1: A synchronous active-high reset leaves the block deselected with the beat counter cleared; `rdata_drv_o` is 0 and `rdata_o` is 0 during and after reset until a transfer is started.
- R2: A start occurs on an edge where `proc_strobe_n` is low with `sel_a_n` low, or where `ctrl_strobe_n` is low. The block is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 on that edge; otherwise it becomes deselected, and it stays so (bus not driven) until the next selecting start.
- R3: When `proc_strobe_n` is low with `sel_a_n` low, the edge is a processor start even if `ctrl_strobe_n` is also low; a processor start is always a read and the write inputs are ignored.
- R4: While `sel_a_n` is high, `proc_strobe_n` has no effect; with `ctrl_strobe_n` high an active burst simply continues.
- R5: The three selects are examined only on start edges; changing them during burst continuation neither deselects nor stalls the burst.
- R6: A selecting start loads `addr_i[1:0]` as base and clears the beat; on a non-start edge while active, `advance_n`=0 increments the 2-bit beat and `advance_n`=1 holds it.
- R7: With `order_i`=0 the word offset is (base + beat) mod 4.
- R8: With `order_i`=1 the word offset is base XOR beat.
- R9: `all_wr_n`=0 on an active non-processor-start edge writes every lane, all 9 bits, regardless of `lane_wr_en_n` and `lane_sel_n`.
- R10: Otherwise lane i (bits [9i+8:9i], parity at bit 9i+8) is written only when `lane_wr_en_n`=0 and `lane_sel_n[i]`=0; with `lane_wr_en_n`=1 nothing is written.
- R11: Writes store at the address in effect after the edge; reads return that address's word during the cycle after the edge.
- R12: `rdata_drv_o` is 0 in the cycle after any write edge, in the first cycle after a deselected-to-selected start, and while deselected, whatever `drive_en_n` is.
- R13: `drive_en_n`=1 forces `rdata_drv_o` to 0 and `rdata_o` to 0 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low, priority |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| addr_i | input | ADDR_W | Word address |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| drive_en_n | input | 1 | Asynchronous bus drive enable, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata_i | input | NB*(BYTE_W+1) | Write data, lane i at [9i+8:9i] |
| rdata_o | output | NB*(BYTE_W+1) | Read data, zero when not driven |
| rdata_drv_o | output | 1 | Data bus drive flag |

## Verification
The bench walks bursts that wrap past offset 3 in both orders. A design that wraps across the word boundary, or that swaps linear and interleaved order, returns the wrong word. It drives both strobes low together with a global write asserted; a design that lets the controller strobe win corrupts a word that is read back afterwards. It changes the selects in the middle of a burst, and a design that re-examines them drops the bus. It checks that the bus stays quiet on the first cycle after selection and after every write, and it checks partial lane writes, including the parity bits, against a merged expected word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_PROC = 2'd1,
    START_CTRL = 2'd2
  } start_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                              input logic [1:0] beat,
                                              input logic       interleave);
    return interleave ? (base ^ beat) : 2'(base + beat);
  endfunction
endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output start_e            start_o,
  output logic              nxt_active_o,
  output logic              active_o,
  output logic              first_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic            active_q, first_q;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      base_q, base_d, beat_q, beat_d;
  logic            picked, load;

  always_comb begin
    if (!proc_strobe_n && !sel_a_n) start_o = START_PROC;
    else if (!ctrl_strobe_n)        start_o = START_CTRL;
    else                            start_o = START_NONE;
    picked = !sel_a_n && sel_b && !sel_c_n;
    load   = (start_o != START_NONE) && picked;
    nxt_active_o = (start_o != START_NONE) ? picked : active_q;
    hi_d   = load ? addr_i[ADDR_W-1:2] : hi_q;
    base_d = load ? addr_i[1:0] : base_q;
    if (load)                                         beat_d = 2'd0;
    else if (start_o == START_NONE && active_q && !advance_n) beat_d = 2'(beat_q + 2'd1);
    else                                              beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      hi_q     <= '0;
      base_q   <= '0;
      beat_q   <= '0;
    end else begin
      active_q <= nxt_active_o;
      first_q  <= nxt_active_o && !active_q;
      hi_q     <= hi_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o   = active_q;
  assign first_o    = first_q;
  assign nxt_addr_o = {hi_d, burst_offset(base_d, beat_d, order_i)};
  assign cur_addr_o = {hi_q, burst_offset(base_q, beat_q, order_i)};

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && proc_strobe_n && ctrl_strobe_n && advance_n) |=> $stable(beat_q));
  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && (proc_strobe_n || sel_a_n) && ctrl_strobe_n && !advance_n)
      |=> beat_q == 2'($past(beat_q) + 2'd1));
  // R2
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_strobe_n && (sel_a_n || !sel_b || sel_c_n)) |=> !active_q);
  // R5
  hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && ctrl_strobe_n && (proc_strobe_n || sel_a_n)) |=> active_q);
endmodule

// File: rtl/sbs_lane_wr.sv
module sbs_lane_wr #(
  parameter int NB = 4
) (
  input  logic          allow_i,
  input  logic          all_wr_n,
  input  logic          lane_wr_en_n,
  input  logic [NB-1:0] lane_sel_n,
  output logic [NB-1:0] lane_we_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_we_o[g] = allow_i && (!all_wr_n || (!lane_wr_en_n && !lane_sel_n[g]));
  end
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int NB     = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic [NB-1:0]      we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [NB*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]  raddr_i,
  output logic [NB*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      proc_strobe_n,
  input  logic                      ctrl_strobe_n,
  input  logic                      advance_n,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      all_wr_n,
  input  logic                      lane_wr_en_n,
  input  logic [NB-1:0]             lane_sel_n,
  input  logic                      drive_en_n,
  input  logic                      order_i,
  input  logic [NB*(BYTE_W+1)-1:0]  wdata_i,
  output logic [NB*(BYTE_W+1)-1:0]  rdata_o,
  output logic                      rdata_drv_o
);
  localparam int LANE_W = BYTE_W + 1;
  localparam int DW     = NB * LANE_W;

  start_e            start;
  logic              nxt_active, active, first, wrote_q, allow;
  logic [ADDR_W-1:0] nxt_addr, cur_addr;
  logic [NB-1:0]     lane_we;
  logic [DW-1:0]     arr_rd;

  sbs_addr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .order_i(order_i), .addr_i(addr_i),
    .start_o(start), .nxt_active_o(nxt_active), .active_o(active), .first_o(first),
    .nxt_addr_o(nxt_addr), .cur_addr_o(cur_addr)
  );

  assign allow = !rst && nxt_active && (start != START_PROC);

  sbs_lane_wr #(.NB(NB)) wr_i (
    .allow_i(allow), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .lane_we_o(lane_we)
  );

  sbs_store #(.NB(NB), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .we_i(lane_we), .waddr_i(nxt_addr), .wdata_i(wdata_i),
    .raddr_i(cur_addr), .rdata_o(arr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) wrote_q <= 1'b0;
    else     wrote_q <= |lane_we;
  end

  assign rdata_drv_o = active && !first && !wrote_q && !drive_en_n;
  assign rdata_o     = rdata_drv_o ? arr_rd : '0;

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (start == START_PROC) |-> lane_we == '0);
  // R12
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(|lane_we) |-> !rdata_drv_o);
  // R13
  drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en_n |-> (!rdata_drv_o && rdata_o == '0));
  // R12
  first_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> !rdata_drv_o);
endmodule

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  typedef struct packed {
    logic        ps, cs, av;
    logic [2:0]  sel;
    logic        aw, le;
    logic [3:0]  ls;
    logic        de, ord;
    logic [5:0]  a;
    logic [35:0] wd;
    logic        eoe;
    logic [35:0] erd;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic ps, cs, av, input logic [2:0] sel,
                              input logic aw, le, input logic [3:0] ls,
                              input logic de, ord, input logic [5:0] a,
                              input logic [35:0] wd, input logic eoe,
                              input logic [35:0] erd, input int req);
    vec_t v;
    v.ps = ps; v.cs = cs; v.av = av; v.sel = sel; v.aw = aw; v.le = le;
    v.ls = ls; v.de = de; v.ord = ord; v.a = a; v.wd = wd; v.eoe = eoe;
    v.erd = erd; v.req = 4'(req);
    return v;
  endfunction

  function automatic logic [35:0] mrg(input logic [35:0] old_w, new_w, input logic [3:0] ls);
    logic [35:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++) if (!ls[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  // select code {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] SL = 3'b010, NB2 = 3'b000, NC3 = 3'b011, NA1 = 3'b100;
  localparam logic [35:0] W4 = 36'h4A1B2C3D4, W5 = 36'h5E6F70815, W6 = 36'h692A3B4C6,
                          W7 = 36'h7D5E6F707, W6B = 36'hC3C3C3C3C, JK = 36'h111111111,
                          NW = 36'h0;
  localparam logic [35:0] W6M = mrg(W6, NW, 4'b1010);
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    mk(1,0,1,SL,0,1,4'hF,0,0,4,W4,0,0,12),   // R12 first cycle + write
    mk(1,1,0,SL,0,1,4'hF,0,0,0,W5,0,0,9),    // R9
    mk(1,1,0,SL,0,1,4'hF,0,0,0,W6,0,0,9),
    mk(1,1,0,SL,0,1,4'hF,0,0,0,W7,0,0,9),
    mk(1,1,1,SL,1,1,4'hF,0,0,0,JK,1,W7,6),   // R6 hold
    mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,1,W4,7),   // R7 wrap
    mk(0,1,1,SL,1,1,4'hF,0,0,6,JK,1,W6,11),  // R11
    mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,1,W7,7),
    mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,1,W4,7),
    mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,1,W5,7),
    mk(1,1,1,SL,1,1,4'hF,1,0,0,JK,0,0,13),   // R13
    mk(0,1,1,SL,1,1,4'hF,0,1,5,JK,1,W5,8),   // R8
    mk(1,1,0,SL,1,1,4'hF,0,1,0,JK,1,W4,8),
    mk(1,1,0,SL,1,1,4'hF,0,1,0,JK,1,W7,8),
    mk(1,1,0,SL,1,1,4'hF,0,1,0,JK,1,W6,8),
    mk(1,1,1,SL,1,0,4'b1010,0,1,0,NW,0,0,10), // R10
    mk(1,1,1,SL,1,1,4'hF,0,1,0,JK,1,W6M,10),
    mk(1,1,1,SL,1,1,4'h0,0,1,0,JK,1,W6M,10),
    mk(1,1,1,SL,0,1,4'hF,0,1,0,W6B,0,0,9),
    mk(1,1,1,SL,1,1,4'hF,0,1,0,JK,1,W6B,9),
    mk(0,0,1,SL,0,0,4'h0,0,1,4,JK,1,W4,3),   // R3
    mk(1,1,1,SL,1,1,4'hF,0,1,0,JK,1,W4,3),
    mk(0,1,0,NA1,1,1,4'hF,0,1,0,JK,1,W5,4),  // R4
    mk(1,0,1,NB2,1,1,4'hF,0,1,7,JK,0,0,2),   // R2
    mk(1,1,0,SL,1,1,4'hF,0,1,0,JK,0,0,2),
    mk(1,0,1,SL,1,1,4'hF,0,1,7,JK,0,0,12),
    mk(1,1,1,SL,1,1,4'hF,0,1,0,JK,1,W7,12),
    mk(0,1,1,NC3,1,1,4'hF,0,1,4,JK,0,0,2),
    mk(0,1,1,SL,1,1,4'hF,0,1,4,JK,0,0,12),
    mk(1,1,0,SL,1,1,4'hF,0,1,0,JK,1,W5,6),
    mk(1,1,0,NB2,1,1,4'hF,0,1,0,JK,1,W6B,5)  // R5
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ps_n, cs_n, av_n, sa_n, sb, sc_n, aw_n, le_n, de_n, ord;
  logic [5:0]  addr;
  logic [3:0]  ls_n;
  logic [35:0] wd, rd;
  logic        drv;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram dut_i (
    .clk(clk), .rst(rst), .proc_strobe_n(ps_n), .ctrl_strobe_n(cs_n),
    .advance_n(av_n), .sel_a_n(sa_n), .sel_b(sb), .sel_c_n(sc_n), .addr_i(addr),
    .all_wr_n(aw_n), .lane_wr_en_n(le_n), .lane_sel_n(ls_n), .drive_en_n(de_n),
    .order_i(ord), .wdata_i(wd), .rdata_o(rd), .rdata_drv_o(drv)
  );

  task automatic drive(input vec_t v);
    ps_n = v.ps; cs_n = v.cs; av_n = v.av; {sa_n, sb, sc_n} = v.sel;
    aw_n = v.aw; le_n = v.le; ls_n = v.ls; de_n = v.de; ord = v.ord;
    addr = v.a; wd = v.wd;
  endtask

  task automatic chk(input int req, input logic eoe, input logic [35:0] erd);
    n_run++;
    if (drv !== eoe || rd !== erd) begin
      n_fail++;
      $display("FAIL R%0d drv=%b/%b rdata=%h/%h (actual/expected)", req, drv, eoe, rd, erd);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  initial begin
    drive(mk(1,1,1,SL,1,1,4'hF,0,0,0,JK,0,0,1));
    repeat (3) step();
    chk(1, 0, 0);                                  // R1 during reset
    rst = 0;
    step();
    chk(1, 0, 0);                                  // R1 no start yet
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step();
      chk(int'(VEC[i].req), VEC[i].eoe, VEC[i].erd);
    end
    // R1 reset in the middle of an active burst
    drive(mk(1,1,1,SL,1,1,4'hF,0,0,0,JK,0,0,1));
    rst = 1;
    step(); step();
    chk(1, 0, 0);
    rst = 0;
    drive(mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,0,0,1));
    step();
    chk(1, 0, 0);                                  // R1 advance alone does not select
    drive(mk(1,0,1,SL,1,1,4'hF,0,0,5,JK,0,0,6));
    step();
    chk(6, 0, 0);                                  // R12 first cycle quiet
    drive(mk(1,1,0,SL,1,1,4'hF,0,0,0,JK,0,0,6));
    step();
    chk(6, 1, W6B);                                // R6 base 1 beat 1 linear -> 6
    drive(mk(1,1,1,SL,1,1,4'hF,1,0,0,JK,0,0,13));
    #2 chk(13, 0, 0);                              // R13 combinational
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog expired drv=%b rdata=%h (actual/expected finished)", drv, rd);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule